// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects event pulses from seven peripheral sources of a small 8-bit processor core and turns them into one interrupt request with a fixed vector. The sources are two external pins, two timers, an analog-to-digital converter, a watchdog and an interval timer. Each source owns a sticky pending flag and an enable bit. Both sit in byte-wide registers that the core reads and writes over a simple bus. A global master enable gates every source at once.

The request output to the core goes high when the master enable is set and at least one source is both pending and enabled. The vector output carries the 16-bit service address of the highest-priority source that is pending and enabled. The core samples the vector when it pulses `irq_ack`. That acknowledge clears the master enable, so no nested request follows. The pending flag stays set until software writes it to 0.

The core sets and clears the master enable through two dedicated strobes. These stand in for the enable and disable instructions and for the status restore on return from interrupt. Request and acknowledge form a valid/ready pair for a single vector word. The vector stays stable while `irq_req` is high and no register is written. Nothing is lost if the core delays `irq_ack`, because the request is level-held.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Source index 0..6 means INT0, INT1, Timer0, Timer1, ADC, watchdog, interval timer. The enable bytes sit at address E2H (sources 0..3 on bits 7,6,5,4) and E3H (sources 4..6 on bits 7,6,5). The pending bytes sit at E4H and E5H and use the same bit positions. All of these read back what was written.
- R2: Unused bits read 0, and writing them has no effect. Every other address reads 00H and ignores writes. After reset every register reads 00H.
- R3: A one-cycle high on `src_pulse[i]` sets pending flag i at the next clock edge. The flag then holds until software writes 0 to its bit. Writing 1 also sets it.
- R4: When a source pulse and a software write of 0 to that pending bit fall in the same cycle, the flag ends up set.
- R5: `irq_req` is high exactly when the master enable is 1 and some source is both pending and enabled. It follows register state with no extra cycle of delay.
- R6: `irq_vector` gives the vector of the lowest-index source that is pending and enabled. The vectors for sources 0..6 are FFFAH, FFF8H, FFF6H, FFF4H, FFEAH, FFE8H and FFE6H. The master enable does not affect this output.
- R7: When no source is both pending and enabled, `irq_vector` reads FFFEH.
- R8: An `irq_ack` pulse clears the master enable at the next edge and leaves every pending flag unchanged.
- R9: The master enable resets to 0. `iflag_set` sets it. `iflag_clr` and `irq_ack` each override `iflag_set` in the same cycle. `master_en` shows its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| src_pulse | input | 7 | Event pulses, index = source number |
| iflag_set | input | 1 | Set the master enable |
| iflag_clr | input | 1 | Clear the master enable |
| irq_ack | input | 1 | Core accepts the vector (one cycle) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 16 | Service address of the winning source |
| master_en | output | 1 | Current master enable |

## Verification
The bench sweeps all 128 pending patterns with every source enabled, then all 128 enable patterns with every source pending. A priority encoder that favoured the wrong end, or a swapped vector entry, would give a wrong address on many of these patterns. The all-zero patterns would expose a missing FFFEH default. Directed cases target a pulse that collides with a software clear, where a write-wins flag would drop the event. An acknowledge issued together with a set strobe would leave a wrongly ordered master flag enabled. After an acknowledge the bench reads the pending flags back, to catch a controller that auto-clears them. It also reads unmapped addresses and unused bits, which would show stray storage or a loose address decode.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 7;
  localparam int NHI  = 4;
  localparam int NLO  = NSRC - NHI;
  localparam logic [7:0] A_EN_HI = 8'hE2;
  localparam logic [7:0] A_EN_LO = 8'hE3;
  localparam logic [7:0] A_RQ_HI = 8'hE4;
  localparam logic [7:0] A_RQ_LO = 8'hE5;
  localparam logic [15:0] VEC_NONE = 16'hFFFE;

  function automatic logic [15:0] vec_of(input int idx);
    case (idx)
      0: return 16'hFFFA;
      1: return 16'hFFF8;
      2: return 16'hFFF6;
      3: return 16'hFFF4;
      4: return 16'hFFEA;
      5: return 16'hFFE8;
      6: return 16'hFFE6;
      default: return VEC_NONE;
    endcase
  endfunction

  // bit position of source idx inside its byte
  function automatic int bitpos(input int idx);
    return (idx < NHI) ? 7 - idx : 7 - (idx - NHI);
  endfunction
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_pulse,
  input  logic [N-1:0] en_wr,
  input  logic [N-1:0] rq_wr,
  input  logic [N-1:0] wbit,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pend_q
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        if (en_wr[i]) en_q[i] <= wbit[i];
        // a pulse overrides a simultaneous software clear
        pend_q[i] <= (rq_wr[i] ? wbit[i] : pend_q[i]) | src_pulse[i];
      end
    end
  end

  // R3
  // pending flags only fall through a software write
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_wr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R4
  // every pulse lands in its flag
  pulse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0) |=> ((pend_q & $past(src_pulse)) == $past(src_pulse)));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] active,
  output logic [N-1:0] grant,
  output logic         any,
  output logic [15:0]  vector
);
  always_comb begin
    grant  = '0;
    vector = VEC_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        vector   = vec_of(i);
      end
    end
  end

  assign any = |active;

  // R6
  // at most one winner and it is an active source
  grant_ok_chk: assert property (@(active) 1'b1 |-> ($onehot0(grant) && ((grant & ~active) == '0)))
    else $error("grant_ok_chk");
endmodule

// File: rtl/irq_master.sv
module irq_master (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              en_o <= 1'b0;
    else if (ack_i || clr_i) en_o <= 1'b0;
    else if (set_i)          en_o <= 1'b1;
  end

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !en_o);

  // R9
  set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !ack_i) |=> en_o);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [6:0]  src_pulse,
  input  logic        iflag_set,
  input  logic        iflag_clr,
  input  logic        irq_ack,
  output logic        irq_req,
  output logic [15:0] irq_vector,
  output logic        master_en
);
  logic [NSRC-1:0] en_wr, rq_wr, wbit, en_q, pend_q, active, grant;
  logic            any_act;

  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    localparam int P = bitpos(i);
    localparam logic [7:0] AEN = (i < NHI) ? A_EN_HI : A_EN_LO;
    localparam logic [7:0] ARQ = (i < NHI) ? A_RQ_HI : A_RQ_LO;
    assign wbit[i]  = bus_wdata[P];
    assign en_wr[i] = bus_we && (bus_addr == AEN);
    assign rq_wr[i] = bus_we && (bus_addr == ARQ);
  end

  irq_src_regs #(.N(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .en_wr(en_wr), .rq_wr(rq_wr), .wbit(wbit),
    .en_q(en_q), .pend_q(pend_q)
  );

  assign active = en_q & pend_q;

  irq_prio_sel #(.N(NSRC)) u_sel (
    .active(active), .grant(grant), .any(any_act), .vector(irq_vector)
  );

  irq_master u_mst (
    .clk(clk), .rst_n(rst_n), .set_i(iflag_set), .clr_i(iflag_clr),
    .ack_i(irq_ack), .en_o(master_en)
  );

  assign irq_req = master_en & any_act;

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NSRC; i++) begin
      if ((i < NHI && bus_addr == A_EN_HI) || (i >= NHI && bus_addr == A_EN_LO))
        bus_rdata[bitpos(i)] = en_q[i];
      if ((i < NHI && bus_addr == A_RQ_HI) || (i >= NHI && bus_addr == A_RQ_LO))
        bus_rdata[bitpos(i)] = pend_q[i];
    end
  end

  // R5
  req_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (master_en && irq_vector != VEC_NONE));

  // R8
  ack_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !bus_we) |=> (pend_q == ($past(pend_q) | $past(src_pulse))));
endmodule

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic bus_we = 0;
  logic [7:0] bus_rdata;
  logic [6:0] src_pulse = 0;
  logic iflag_set = 0, iflag_clr = 0, irq_ack = 0;
  logic irq_req, master_en;
  logic [15:0] irq_vector;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vec_ctrl dut (.*);

  function automatic logic [15:0] tbl(input int i);
    case (i)
      0: return 16'hFFFA; 1: return 16'hFFF8; 2: return 16'hFFF6;
      3: return 16'hFFF4; 4: return 16'hFFEA; 5: return 16'hFFE8;
      6: return 16'hFFE6; default: return 16'hFFFE;
    endcase
  endfunction

  function automatic logic [15:0] exp_vec(input logic [6:0] a);
    logic [15:0] v = 16'hFFFE;
    for (int i = 6; i >= 0; i--) if (a[i]) v = tbl(i);
    return v;
  endfunction

  function automatic logic [7:0] hi_b(input logic [6:0] p);
    return {p[0], p[1], p[2], p[3], 4'b0};
  endfunction
  function automatic logic [7:0] lo_b(input logic [6:0] p);
    return {p[4], p[5], p[6], 5'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, {24'b0, bus_rdata}, {24'b0, exp});
  endtask

  task automatic strobe(input bit s, input bit c, input bit k);
    @(negedge clk); iflag_set = s; iflag_clr = c; irq_ack = k;
    @(negedge clk); iflag_set = 0; iflag_clr = 0; irq_ack = 0;
  endtask

  task automatic setp(input logic [6:0] p);
    wr(8'hE4, hi_b(p)); wr(8'hE5, lo_b(p));
  endtask
  task automatic sete(input logic [6:0] e);
    wr(8'hE2, hi_b(e)); wr(8'hE3, lo_b(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    rd(8'hE2, 8'h00, "R2 reset E2"); rd(8'hE3, 8'h00, "R2 reset E3");
    rd(8'hE4, 8'h00, "R2 reset E4"); rd(8'hE5, 8'h00, "R2 reset E5");
    chk("R9 reset master", {31'b0, master_en}, 0);
    chk("R5 reset req", {31'b0, irq_req}, 0);
    chk("R7 reset vector", {16'b0, irq_vector}, 32'hFFFE);
    // R1 / R2 field layout and unused bits
    wr(8'hE2, 8'hFF); rd(8'hE2, 8'hF0, "R1 R2 E2 mask");
    wr(8'hE3, 8'hFF); rd(8'hE3, 8'hE0, "R1 R2 E3 mask");
    wr(8'hE2, 8'hA0); rd(8'hE2, 8'hA0, "R1 E2 pattern");
    wr(8'hE3, 8'h40); rd(8'hE3, 8'h40, "R1 E3 pattern");
    wr(8'hE6, 8'hFF); rd(8'hE6, 8'h00, "R2 unmapped E6");
    rd(8'hE1, 8'h00, "R2 unmapped E1");
    rd(8'hE2, 8'hA0, "R2 E2 untouched"); rd(8'hE4, 8'h00, "R2 E4 untouched");
    wr(8'hE3, 8'h00); wr(8'hE2, 8'h00);
    // R3 each pulse sets its own flag and it holds
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); src_pulse = 7'(1 << i);
      @(negedge clk); src_pulse = 0;
      repeat (2) @(negedge clk);
      rd(8'hE4, hi_b(7'(1 << i)), "R3 pulse hi");
      rd(8'hE5, lo_b(7'(1 << i)), "R3 pulse lo");
      setp(0);
    end
    // R4 pulse against a clear in the same cycle
    setp(7'h7F);
    @(negedge clk); bus_addr = 8'hE4; bus_wdata = 8'h00; bus_we = 1; src_pulse = 7'h02;
    @(negedge clk); bus_we = 0; src_pulse = 0;
    rd(8'hE4, 8'h40, "R4 pulse wins over clear");
    setp(0);
    // R9 master strobes
    strobe(1, 0, 0); chk("R9 set", {31'b0, master_en}, 1);
    strobe(0, 1, 0); chk("R9 clr", {31'b0, master_en}, 0);
    strobe(1, 1, 0); chk("R9 clr beats set", {31'b0, master_en}, 0);
    strobe(1, 0, 1); chk("R9 ack beats set", {31'b0, master_en}, 0);
    // R5 master off gates request
    sete(7'h7F); setp(7'h7F);
    chk("R5 no req without master", {31'b0, irq_req}, 0);
    chk("R6 vector ignores master", {16'b0, irq_vector}, 32'hFFFA);
    // R8 ack clears master, flags stay
    setp(7'h02); strobe(1, 0, 0);
    chk("R5 req on", {31'b0, irq_req}, 1);
    chk("R6 vector INT1", {16'b0, irq_vector}, 32'hFFF8);
    strobe(0, 0, 1);
    chk("R8 master cleared", {31'b0, master_en}, 0);
    chk("R8 req dropped", {31'b0, irq_req}, 0);
    rd(8'hE4, 8'h40, "R8 flag kept");
    // R6 / R7 sweep of pending with all enabled
    strobe(1, 0, 0);
    for (int p = 0; p < 128; p++) begin
      setp(7'(p));
      chk("R6 R7 pend sweep vector", {16'b0, irq_vector}, {16'b0, exp_vec(7'(p))});
      chk("R5 pend sweep req", {31'b0, irq_req}, {31'b0, (p != 0)});
    end
    // R6 / R7 sweep of enables with all pending
    setp(7'h7F);
    for (int e = 0; e < 128; e++) begin
      sete(7'(e));
      chk("R6 R7 en sweep vector", {16'b0, irq_vector}, {16'b0, exp_vec(7'(e))});
      chk("R5 en sweep req", {31'b0, irq_req}, {31'b0, (e != 0)});
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule